// File: doc/BRIEF.md
# Low-Speed USB Serial Transmitter

This block turns a packet handed over as a stream of bytes into the line signals for a low-speed USB link. A start strobe carries the packet length. That length counts the sync byte, which the block inserts itself. The block then takes the remaining bytes one at a time over a ready/valid input. It claims the bus and holds the idle level for one bit time. It sends the sync byte and then the packet bytes, lowest bit first. NRZI coding and bit stuffing are applied throughout. The packet closes with the end-of-packet sequence, and then the bus is released.

Each bit lasts eight system clocks, which gives 1.5 Mbit/s from a 12 MHz clock. A parameter can switch this to an external bit-rate enable instead of the internal divider. Stuffing and NRZI share one run counter. That counter carries across byte boundaries, and it can add a stuffed bit just before the end of packet.

The start strobe also marks the packet as data or handshake. When a data packet finishes, the block copies a pending device address into its active address register and pulses a commit flag. Every finished packet also gives a one-cycle pulse that clears the receive-start flag set by the block's own traffic.

Top module: `ls_serial_tx`

## Requirements
- R1: After reset and while idle, `usb_oe`, `usb_dp`, `usb_dm`, `busy` and `in_ready` are all 0.
- R2: A start with a nonzero count raises `usb_oe` and drives the idle level J (`usb_dp`=0, `usb_dm`=1) for one bit time before the first sync bit.
- R3: Each bit lasts 8 clocks. The byte 0x80 goes first, then `byte_cnt`-1 bytes from the input stream, each least-significant bit first.
- R4: NRZI coding is used. A 0 bit swaps the line between J and K (`usb_dp`=1, `usb_dm`=0), and a 1 bit repeats the previous level. During data the two lines are always complementary.
- R5: After six 1 bits in a row, one extra bit time is inserted that swaps the level. The run count carries across byte boundaries, so this also happens just before the end of packet.
- R6: After the last bit, both lines are low for exactly 2 bit times, then J for 1 bit time. After that, `usb_oe`, `usb_dp`, `usb_dm` and `busy` return to 0.
- R7: A packet started with `is_data`=1 ends with one `addr_commit` pulse, and `dev_addr` takes `pending_addr`. A packet with `is_data`=0 gives no pulse and leaves `dev_addr` unchanged.
- R8: Every packet ends with exactly one single-cycle `rx_flag_clr` pulse.
- R9: A start with `byte_cnt`=0 is ignored: the block stays idle and the bus is not claimed.
- R10: The next input byte is accepted before the current byte's last bit ends, so all bytes are taken and sent back to back, with no extra bit times between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 per bit) |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | External bit-rate enable, used only when EXT_TICK=1 |
| start | input | 1 | Begin a packet (taken when idle) |
| byte_cnt | input | CNT_W | Packet length including the sync byte |
| is_data | input | 1 | 1 = data packet, 0 = handshake |
| in_data | input | 8 | Next packet byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block accepts in_data this cycle |
| pending_addr | input | ADDR_W | Address to commit after a data packet |
| busy | output | 1 | Packet in progress |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Line drivers enabled |
| addr_commit | output | 1 | One-cycle pulse: address committed |
| dev_addr | output | ADDR_W | Active device address |
| rx_flag_clr | output | 1 | One-cycle pulse clearing the receive-start flag |

## Verification
The bench decodes the line back to bits, drops the stuffed bits and compares the result with the sync byte plus the bytes it supplied. Alternating patterns such as 0x5A and 0xC3 test the coding of 0s against 1s. A zero byte makes every bit time swap the level. A run of eight 0xFF bytes forces stuffing several times, including across byte boundaries. A byte with six 1s followed by 0s shows that a stuffed bit goes in ahead of a real 0. A final byte ending in six 1s needs a stuffed bit right before the end of packet. A sync-only packet and handshake packets show that the address commit depends on the packet type, not on the length.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BITS,
        ST_SE0,
        ST_JEND
    } tx_state_e;

    localparam int          BYTE_W        = 8;
    localparam logic [7:0]  SYNC_PATTERN  = 8'h80;
    localparam int          RUN_LIMIT     = 6;
    localparam int          EOP_SE0_SLOTS = 2;

endpackage

// File: rtl/ls_tx_tick.sv
module ls_tx_tick #(
    parameter int DIV      = 8,
    parameter bit EXT_TICK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_tick,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (EXT_TICK) begin : g_ext
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign tick       = run & ext_tick;
        end else begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;
            logic          unused_ext;
            assign unused_ext = ext_tick;

            always_comb begin
                cnt_d = cnt_q;
                if (!run || cnt_q == CW'(DIV - 1)) cnt_d = '0;
                else                               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run & (cnt_q == CW'(DIV - 1));

            // R3: bit enable never lasts two cycles in a row
            assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ls_tx_coder.sv
module ls_tx_coder
    import ls_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    input  logic bit_in,
    output logic lvl,
    output logic need_stuff
);
    localparam int RW = $clog2(RUN_LIMIT + 1);

    typedef struct packed {
        logic          lvl;
        logic [RW-1:0] run;
    } coder_t;

    coder_t d, q;

    always_comb begin
        d = q;
        if (init) begin
            d.lvl = 1'b1;
            d.run = RW'(RUN_LIMIT);
        end else if (step) begin
            if (q.run == '0 || !bit_in) begin
                d.lvl = ~q.lvl;
                d.run = RW'(RUN_LIMIT);
            end else begin
                d.run = q.run - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lvl <= 1'b1;
            q.run <= RW'(RUN_LIMIT);
        end else begin
            q <= d;
        end
    end

    assign lvl        = q.lvl;
    assign need_stuff = (q.run == '0);

    // R5: an exhausted run forces a level swap and restarts the run
    assert_stuff_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && need_stuff) |=> (lvl != $past(lvl)) && !need_stuff);

    // R4: a 1 bit keeps the level
    assert_one_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && !need_stuff && bit_in) |=> (lvl == $past(lvl)));

    // R5: run counter stays within its limit
    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.run <= RW'(RUN_LIMIT));

endmodule

// File: rtl/ls_tx_seq.sv
module ls_tx_seq
    import ls_tx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              is_data,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] pending_addr,
    input  logic              need_stuff,
    output logic              init,
    output logic              step,
    output logic              bit_out,
    output tx_state_e         state,
    output logic              addr_commit,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              rx_flag_clr
);
    localparam int                LW      = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  ONE_CNT = CNT_W'(1);
    localparam logic [1:0]        SE0_TOP = 2'(EOP_SE0_SLOTS - 1);

    typedef struct packed {
        tx_state_e          state;
        logic [BYTE_W-1:0]  shift;
        logic [LW-1:0]      left;
        logic [BYTE_W-1:0]  hold;
        logic               hold_v;
        logic [CNT_W-1:0]   fetch;
        logic [1:0]         se0;
        logic               data_pkt;
        logic               commit;
        logic               clr;
        logic [ADDR_W-1:0]  addr;
    } seq_t;

    seq_t d, q;
    logic accept;

    assign in_ready = (q.state == ST_PRE || q.state == ST_BITS) && !q.hold_v && (q.fetch != '0);
    assign accept   = in_ready && in_valid;

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        d.clr    = 1'b0;
        init     = 1'b0;
        step     = 1'b0;
        bit_out  = 1'b1;

        if (accept) begin
            d.hold   = in_data;
            d.hold_v = 1'b1;
            d.fetch  = q.fetch - ONE_CNT;
        end

        case (q.state)
            ST_IDLE: begin
                if (start && byte_cnt != '0) begin
                    d.state    = ST_PRE;
                    d.shift    = SYNC_PATTERN;
                    d.left     = LW'(BYTE_W);
                    d.fetch    = byte_cnt - ONE_CNT;
                    d.hold_v   = 1'b0;
                    d.data_pkt = is_data;
                    init       = 1'b1;
                end
            end
            ST_PRE, ST_BITS: begin
                if (tick) begin
                    d.state = ST_BITS;
                    if (need_stuff) begin
                        step = 1'b1;
                    end else if (q.left != '0) begin
                        step    = 1'b1;
                        bit_out = q.shift[0];
                        d.shift = q.shift >> 1;
                        d.left  = q.left - 1'b1;
                    end else if (q.hold_v) begin
                        step     = 1'b1;
                        bit_out  = q.hold[0];
                        d.shift  = q.hold >> 1;
                        d.left   = LW'(BYTE_W - 1);
                        d.hold_v = 1'b0;
                    end else begin
                        d.state  = ST_SE0;
                        d.se0    = SE0_TOP;
                        d.fetch  = '0;
                        d.hold_v = 1'b0;
                    end
                end
            end
            ST_SE0: begin
                if (tick) begin
                    if (q.se0 == '0) d.state = ST_JEND;
                    else             d.se0   = q.se0 - 1'b1;
                end
            end
            ST_JEND: begin
                if (tick) begin
                    d.state = ST_IDLE;
                    d.clr   = 1'b1;
                    if (q.data_pkt) begin
                        d.commit = 1'b1;
                        d.addr   = pending_addr;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.shift    <= '0;
            q.left     <= '0;
            q.hold     <= '0;
            q.hold_v   <= 1'b0;
            q.fetch    <= '0;
            q.se0      <= '0;
            q.data_pkt <= 1'b0;
            q.commit   <= 1'b0;
            q.clr      <= 1'b0;
            q.addr     <= '0;
        end else begin
            q <= d;
        end
    end

    assign state       = q.state;
    assign addr_commit = q.commit;
    assign dev_addr    = q.addr;
    assign rx_flag_clr = q.clr;

    // R9: a zero-length start leaves the block idle
    assert_zero_len_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start && byte_cnt == '0) |=> (q.state == ST_IDLE));

    // R7: commit only follows the final J of a data packet
    assert_commit_data_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_commit |-> (q.data_pkt && $past(q.state == ST_JEND)));

    // R6: the last SE0 slot is followed by J
    assert_se0_then_j_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SE0 && tick && q.se0 == '0) |=> (q.state == ST_JEND));

    // R8: leaving the final J releases and clears the flag
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_JEND && tick) |=> (q.state == ST_IDLE && rx_flag_clr));

    // R10: the holding register is never overwritten while full
    assert_hold_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold_v && !step) |=> q.hold_v || q.state == ST_SE0);

endmodule

// File: rtl/ls_serial_tx.sv
module ls_serial_tx
    import ls_tx_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int ADDR_W   = 7,
    parameter int DIV      = 8,
    parameter bit EXT_TICK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              is_data,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] pending_addr,
    output logic              busy,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              addr_commit,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              rx_flag_clr
);
    tx_state_e state;
    logic      tick, init, step, bit_out, lvl, need_stuff;

    assign busy = (state != ST_IDLE);

    ls_tx_tick #(.DIV(DIV), .EXT_TICK(EXT_TICK)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .ext_tick (bit_tick),
        .tick     (tick)
    );

    ls_tx_coder u_coder (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .step       (step),
        .bit_in     (bit_out),
        .lvl        (lvl),
        .need_stuff (need_stuff)
    );

    ls_tx_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .start        (start),
        .byte_cnt     (byte_cnt),
        .is_data      (is_data),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .pending_addr (pending_addr),
        .need_stuff   (need_stuff),
        .init         (init),
        .step         (step),
        .bit_out      (bit_out),
        .state        (state),
        .addr_commit  (addr_commit),
        .dev_addr     (dev_addr),
        .rx_flag_clr  (rx_flag_clr)
    );

    always_comb begin
        usb_oe = 1'b0;
        usb_dp = 1'b0;
        usb_dm = 1'b0;
        case (state)
            ST_PRE, ST_BITS: begin
                usb_oe = 1'b1;
                usb_dp = ~lvl;
                usb_dm = lvl;
            end
            ST_SE0: usb_oe = 1'b1;
            ST_JEND: begin
                usb_oe = 1'b1;
                usb_dm = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: the bus is claimed in the J level
    assert_claim_in_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_oe) |-> (!usb_dp && usb_dm));

    // R6: release comes straight after a J slot
    assert_release_from_j_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(usb_oe) |-> ($past(usb_dm) && !$past(usb_dp) && !usb_dp && !usb_dm));

endmodule

// File: tb/sim_ls_serial_tx.sv
module sim_ls_serial_tx;
    localparam logic [7:0] SYNC = 8'h80;
    // {count of payload bytes[71:68], flags[67:64] (bit 64 = data packet), bytes (byte i at [8i+:8])}
    localparam int NV = 6;
    localparam logic [71:0] VEC [NV] = '{
        {4'd1, 4'd1, 64'h0000_0000_0000_005A},
        {4'd0, 4'd0, 64'h0000_0000_0000_0000},
        {4'd3, 4'd1, 64'h0000_0000_00FF_00C3},
        {4'd8, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF},
        {4'd2, 4'd0, 64'h0000_0000_0000_7E3F},
        {4'd1, 4'd0, 64'h0000_0000_0000_00FC}
    };

    logic       clk = 1'b0;
    logic       rst_n, bit_tick, start, is_data, in_valid;
    logic [7:0] byte_cnt, in_data;
    logic [6:0] pending_addr, dev_addr, exp_addr;
    logic       in_ready, busy, usb_dp, usb_dm, usb_oe, addr_commit, rx_flag_clr;

    always #10 clk = ~clk;

    ls_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
        .byte_cnt(byte_cnt), .is_data(is_data), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .pending_addr(pending_addr),
        .busy(busy), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe),
        .addr_commit(addr_commit), .dev_addr(dev_addr), .rx_flag_clr(rx_flag_clr)
    );

    int n_chk = 0, n_err = 0, n_commit = 0, n_clr = 0;
    logic gotb [0:127];

    always @(posedge clk) begin
        if (addr_commit) n_commit++;
        if (rx_flag_clr) n_clr++;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run_pkt(input logic [71:0] v, input logic [6:0] paddr);
        int   nb = int'(v[71:68]);
        logic isd = v[64];
        int   ng = 0, stuff_err = 0, bad_lvl = 0, ones = 0, se0 = 0, mism = 0;
        int   c0 = n_commit, l0 = n_clr;
        logic prev = 1'b1, cur, feed_done = 1'b0, expb;
        pending_addr = paddr;
        @(negedge clk);
        byte_cnt = 8'(nb + 1);
        is_data  = isd;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int i = 0; i < nb; i++) begin
                    in_data  = v[8*i +: 8];
                    in_valid = 1'b1;
                    while (!in_ready) @(negedge clk);
                    @(negedge clk);
                end
                in_valid  = 1'b0;
                feed_done = 1'b1;
            end
            begin
                repeat (4) @(negedge clk);
                chk("R2 claim in J", {29'd0, usb_oe, usb_dp, usb_dm}, 32'b101);
                for (int s = 0; s < 200; s++) begin
                    repeat (8) @(negedge clk);
                    if (!usb_dp && !usb_dm) break;
                    if (usb_dp == usb_dm || !usb_oe) begin bad_lvl++; break; end
                    cur = usb_dm;
                    if (ones == 6) begin
                        if (cur == prev) stuff_err++;
                        ones = 0;
                    end else begin
                        if (ng < 128) gotb[ng] = (cur == prev);
                        ng++;
                        ones = (cur == prev) ? ones + 1 : 0;
                    end
                    prev = cur;
                end
                se0 = usb_oe ? 1 : 0;
                repeat (8) @(negedge clk);
                while (usb_oe && !usb_dp && !usb_dm && se0 < 10) begin
                    se0++;
                    repeat (8) @(negedge clk);
                end
                chk("R6 SE0 bit times", se0, 2);
                chk("R6 J after SE0", {29'd0, usb_oe, usb_dp, usb_dm}, 32'b101);
                repeat (8) @(negedge clk);
                chk("R6 released", {28'd0, busy, usb_oe, usb_dp, usb_dm}, 32'd0);
            end
        join
        for (int j = 0; j < ng && j < 128; j++) begin
            expb = (j < 8) ? SYNC[j] : v[j-8];
            if (gotb[j] !== expb) mism++;
        end
        chk("R3 bit count sync plus bytes", ng, 8 * (nb + 1));
        chk("R3/R4 decoded bits LSB first", mism, 0);
        chk("R4 complementary lines", bad_lvl, 0);
        chk("R5 stuffed bits swap level", stuff_err, 0);
        chk("R5 stuff before end of packet", (ones == 6), 0);
        if (isd) exp_addr = paddr;
        chk("R7 commit pulses", n_commit - c0, isd ? 1 : 0);
        chk("R7 active address", dev_addr, exp_addr);
        chk("R8 flag clear pulses", n_clr - l0, 1);
        chk("R10 all bytes taken", feed_done, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_tick = 1'b0; start = 1'b0; is_data = 1'b0;
        in_valid = 1'b0; byte_cnt = '0; in_data = '0; pending_addr = '0;
        exp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 idle outputs", {26'd0, busy, in_ready, usb_oe, usb_dp, usb_dm, addr_commit}, 32'd0);
        chk("R1 address cleared", dev_addr, 0);

        // R9: zero-length start ignored
        byte_cnt = 8'd0; is_data = 1'b1; pending_addr = 7'h55; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 zero count stays idle", {29'd0, busy, usb_oe, rx_flag_clr}, 32'd0);
        chk("R9 zero count no commit", dev_addr, 0);
        chk("R9 zero count no pulses", n_commit + n_clr, 0);

        for (int k = 0; k < NV; k++) begin
            run_pkt(VEC[k], 7'(8'h10 + k));
            repeat (3) @(negedge clk);
        end

        // back-to-back packets with no idle gap between them
        run_pkt({4'd2, 4'd1, 64'h0000_0000_0000_0FF0}, 7'h2A);
        run_pkt({4'd1, 4'd0, 64'h0000_0000_0000_00FF}, 7'h33);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule